// File: doc/BRIEF.md
# Signed Residue-to-Binary Converter

The converter takes one number written as six residues, over the pairwise co-prime moduli 5, 7, 8, 9, 11 and 13, and rebuilds the signed two's-complement integer they encode. It uses the Chinese Remainder Theorem. The product of the moduli is the dynamic range M = 360360. For each modulus m_i, the weight is M_i = M/m_i and T_i is the inverse of M_i modulo m_i. The converter adds the terms a_i·M_i·T_i into a running sum modulo M, one modulus per clock. It then folds the unsigned result onto a range centred on zero. Each term is formed as M_i·((a_i·T_i) mod m_i). That value is already below M, so a single conditional subtraction after each add keeps the running sum reduced.

The fold uses the threshold psi = floor((M−1)/2) = 180179. A reduced sum from 0 to psi is passed through as a non-negative value. A reduced sum above psi has M subtracted from it, which gives a negative value. Because M is even, the output span is −180180 to +180179.

The input side uses a valid/ready handshake and accepts a word only while the converter is idle. The output side has no back-pressure: a one-cycle valid strobe marks a new result, and the result word holds until the next one.

The control is a three-state machine:
- ST_IDLE: `in_ready` is high. An accepted word moves the machine to ST_ACCUM and clears the sum.
- ST_ACCUM: one term is added per cycle, lanes 0 to 5 in order. After lane 5 the machine moves to ST_FOLD.
- ST_FOLD: the signed result is registered and the valid strobe is raised. The machine then returns to ST_IDLE.

Top module: `rns_crt_signed`

## Requirements
- R1: `in_res` carries six 4-bit residue fields. Field i occupies bits [4i+3:4i]. Fields 0 to 5 belong to moduli 5, 7, 8, 9, 11 and 13 in that order.
- R2: A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Every field of an accepted word is below its modulus.
- R3: The running sum is always below M = 360360, and every term added to it is below M.
- R4: When the reduced CRT sum is between 0 and 180179, `out_data` equals that sum.
- R5: When the reduced sum S is above 180179, `out_data` equals S − 360360. The output is therefore never below −180180 and never above 180179.
- R6: A residue vector of all zeros produces `out_data` = 0.
- R7: `out_valid` goes high exactly 7 clock edges after the accepting edge (6 accumulate edges plus 1 fold edge) and stays high for one cycle. `out_data` changes only on the edge that raises `out_valid`.
- R8: `in_ready` is low from the edge after acceptance until the result edge. `in_valid` raised while `in_ready` is low is ignored: the pending result is unaffected and no extra result appears.
- R9: A synchronous active-high `rst` forces `in_ready` = 1, `out_valid` = 0 and `out_data` = 0.
- R10: A new word can be accepted on the clock edge right after the one that raised `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Residue word offered |
| in_ready | output | 1 | Converter idle and able to take a word |
| in_res | input | 24 | Six 4-bit residue fields, field 0 in the low bits |
| out_valid | output | 1 | One-cycle strobe: new result on `out_data` |
| out_data | output | 20 | Signed two's-complement result |

## Verification
The assertions assume that every accepted residue field is a true residue, that is, below its own modulus. Under that assumption, every lane term is below M and the running sum stays reduced. The stimulus never writes residue fields by hand. It picks a signed integer in the range −180180 to 180179 and derives each field with a non-negative remainder, so every field is in range and the expected output is the chosen integer itself. This also applies to the words offered while the converter is busy.

// File: rtl/rns_crt_pkg.sv
package rns_crt_pkg;

    localparam int NUM_MOD = 6;
    localparam int RES_W   = 4;
    localparam int IDX_W   = $clog2(NUM_MOD);

    localparam int unsigned MODULI [NUM_MOD] = '{5, 7, 8, 9, 11, 13};

    function automatic longint unsigned calc_range();
        longint unsigned prod;
        prod = 1;
        for (int i = 0; i < NUM_MOD; i++) begin
            prod = prod * longint'(MODULI[i]);
        end
        return prod;
    endfunction

    localparam longint unsigned DYN_RANGE = calc_range();
    localparam longint unsigned HALF_SPAN = (DYN_RANGE - 1) / 2;
    localparam int              ACC_W     = $clog2(DYN_RANGE);

    function automatic longint unsigned lane_weight(int lane);
        return DYN_RANGE / longint'(MODULI[lane]);
    endfunction

    function automatic longint unsigned lane_inverse(int lane);
        longint unsigned rem;
        longint unsigned md;
        md  = longint'(MODULI[lane]);
        rem = lane_weight(lane) % md;
        for (longint unsigned t = 1; t < md; t++) begin
            if (((rem * t) % md) == 1) begin
                return t;
            end
        end
        return 0;
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_FOLD  = 2'd2
    } conv_state_e;

endpackage

// File: rtl/rns_term_gen.sv
module rns_term_gen
    import rns_crt_pkg::*;
#(
    parameter int LANES = NUM_MOD,
    parameter int FW    = RES_W,
    parameter int SW    = IDX_W,
    parameter int TW    = ACC_W
) (
    input  logic [LANES*FW-1:0] res_vec,
    input  logic [SW-1:0]       sel,
    output logic [TW-1:0]       term
);

    localparam int PW = 16;

    logic [TW-1:0] lane_term [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam longint unsigned MOD_G = longint'(MODULI[g]);
        localparam longint unsigned WGT_G = lane_weight(g);
        localparam longint unsigned INV_G = lane_inverse(g);

        logic [FW-1:0] digit_in;
        logic [PW-1:0] scaled;
        logic [PW-1:0] digit_red;

        assign digit_in  = res_vec[g*FW +: FW];
        assign scaled    = PW'(digit_in) * PW'(INV_G);
        assign digit_red = scaled % PW'(MOD_G);
        assign lane_term[g] = TW'(64'(digit_red) * WGT_G);
    end

    always_comb begin
        term = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sel == SW'(i)) begin
                term = lane_term[i];
            end
        end
    end

endmodule

// File: rtl/rns_mod_acc.sv
module rns_mod_acc
    import rns_crt_pkg::*;
#(
    parameter int              AW      = ACC_W,
    parameter longint unsigned MODULUS = DYN_RANGE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          add_en,
    input  logic [AW-1:0] term,
    output logic [AW-1:0] acc
);

    localparam logic [AW:0] MOD_W = (AW+1)'(MODULUS);

    logic [AW:0] sum_raw;
    logic [AW:0] sum_red;

    assign sum_raw = {1'b0, acc} + {1'b0, term};
    assign sum_red = (sum_raw >= MOD_W) ? (sum_raw - MOD_W) : sum_raw;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (add_en) begin
            acc <= sum_red[AW-1:0];
        end
    end

    AST_ACC_BELOW_M: assert property (@(posedge clk) disable iff (rst)
        {1'b0, acc} < MOD_W); // R3

    AST_TERM_BELOW_M: assert property (@(posedge clk) disable iff (rst)
        add_en |-> ({1'b0, term} < MOD_W)); // R3

endmodule

// File: rtl/rns_sign_fold.sv
module rns_sign_fold
    import rns_crt_pkg::*;
#(
    parameter int              AW      = ACC_W,
    parameter int              OW      = 20,
    parameter longint unsigned MODULUS = DYN_RANGE,
    parameter longint unsigned THRESH  = HALF_SPAN
) (
    input  logic [AW-1:0]        acc,
    output logic signed [OW-1:0] value
);

    localparam logic signed [OW-1:0] MOD_S = OW'(MODULUS);

    logic signed [OW-1:0] widened;
    logic                 above;

    assign widened = signed'(OW'(acc));
    assign above   = (acc > AW'(THRESH));

    always_comb begin
        if (above) begin
            value = widened - MOD_S;
        end else begin
            value = widened;
        end
    end

endmodule

// File: rtl/rns_crt_signed.sv
module rns_crt_signed
    import rns_crt_pkg::*;
#(
    parameter int FW = RES_W,
    parameter int OW = 20
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [NUM_MOD*FW-1:0]  in_res,
    output logic                   out_valid,
    output logic signed [OW-1:0]   out_data
);

    localparam logic [IDX_W-1:0]    LAST_IDX = IDX_W'(NUM_MOD - 1);
    localparam logic signed [OW-1:0] OUT_HI  = OW'(HALF_SPAN);
    localparam logic signed [OW-1:0] OUT_LO  = -OW'(DYN_RANGE - HALF_SPAN - 1);

    conv_state_e              state;
    conv_state_e              state_nxt;
    logic [IDX_W-1:0]         idx;
    logic [NUM_MOD*FW-1:0]    res_q;
    logic                     accept;
    logic [ACC_W-1:0]         term;
    logic [ACC_W-1:0]         acc;
    logic signed [OW-1:0]     folded;

    assign in_ready = (state == ST_IDLE);
    assign accept   = in_valid && in_ready;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (in_valid)        state_nxt = ST_ACCUM;
            ST_ACCUM: if (idx == LAST_IDX) state_nxt = ST_FOLD;
            ST_FOLD:                       state_nxt = ST_IDLE;
            default:                       state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            res_q <= '0;
        end else begin
            state <= state_nxt;
            if (accept) begin
                res_q <= in_res;
            end
            if (state == ST_ACCUM) begin
                idx <= idx + 1'b1;
            end else begin
                idx <= '0;
            end
        end
    end

    rns_term_gen #(
        .LANES (NUM_MOD),
        .FW    (FW),
        .SW    (IDX_W),
        .TW    (ACC_W)
    ) u_term (
        .res_vec (res_q),
        .sel     (idx),
        .term    (term)
    );

    rns_mod_acc #(
        .AW      (ACC_W),
        .MODULUS (DYN_RANGE)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .add_en (state == ST_ACCUM),
        .term   (term),
        .acc    (acc)
    );

    rns_sign_fold #(
        .AW      (ACC_W),
        .OW      (OW),
        .MODULUS (DYN_RANGE),
        .THRESH  (HALF_SPAN)
    ) u_fold (
        .acc   (acc),
        .value (folded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= (state == ST_FOLD);
            if (state == ST_FOLD) begin
                out_data <= folded;
            end
        end
    end

    for (genvar g = 0; g < NUM_MOD; g++) begin : g_chk
        AST_RESIDUE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
            accept |-> (32'(in_res[g*FW +: FW]) < MODULI[g])); // R2
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready); // R8

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R7

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data)); // R7

    AST_OUT_SPAN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data >= OUT_LO && out_data <= OUT_HI)); // R5

endmodule

// File: tb/sim_rns_crt_signed.sv
module sim_rns_crt_signed;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_res = '0;
    logic        out_valid;
    logic signed [19:0] out_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rns_crt_signed u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_res    (in_res),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int mods [6] = '{5, 7, 8, 9, 11, 13};

    function automatic logic [23:0] encode(int x);
        logic [23:0] v;
        v = '0;
        for (int i = 0; i < 6; i++) begin
            int r;
            r = x % mods[i];
            if (r < 0) r = r + mods[i];
            v[i*4 +: 4] = 4'(r);
        end
        return v;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(in_ready == 1'b1, "R9", "in_ready after reset", longint'(in_ready), 1);
        chk(out_valid == 1'b0, "R9", "out_valid after reset", longint'(out_valid), 0);
        chk(out_data == 0, "R9", "out_data after reset", longint'(out_data), 0);
    endtask

    task automatic convert(int x, string req);
        int cnt;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_res   = encode(x);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        cnt = 0;
        while (!out_valid && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == 7, "R7", "latency in cycles", cnt, 7);
        chk(int'(out_data) == x, req, "converted value", longint'(out_data), x);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "strobe width", longint'(out_valid), 0);
        chk(int'(out_data) == x, "R7", "value held", longint'(out_data), x);
    endtask

    task automatic test_busy_ignore(int x, int intruder);
        int cnt;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_res   = encode(x);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        in_valid = 1'b1;
        in_res   = encode(intruder);
        for (int k = 0; k < 3; k++) begin
            chk(in_ready == 1'b0, "R8", "in_ready while busy", longint'(in_ready), 0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        cnt = 4;
        while (!out_valid && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == 7, "R8", "latency with busy offer", cnt, 7);
        chk(int'(out_data) == x, "R8", "result unaffected by busy offer", longint'(out_data), x);
        cnt = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (out_valid) cnt++;
        end
        chk(cnt == 0, "R8", "no extra result", cnt, 0);
    endtask

    task automatic test_back_to_back(int a, int b);
        int cnt;
        convert(a, "R10");
        cnt = 0;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_res   = encode(b);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        while (!out_valid && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == 7, "R10", "second latency", cnt, 7);
        chk(int'(out_data) == b, "R10", "second value", longint'(out_data), b);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        convert(0, "R6");
        convert(1, "R4");
        convert(12345, "R4");
        convert(180179, "R4");
        convert(-1, "R5");
        convert(-98765, "R5");
        convert(-180179, "R5");
        convert(-180180, "R5");
        convert(13, "R1");
        convert(8 * 9 * 11, "R1");
        test_busy_ignore(4242, -777);
        test_back_to_back(-5000, 77777);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule